// File: doc/BRIEF.md
# Event-Driven Synaptic Accumulate Core

This core evaluates one layer slice of a neural network. Pre-synaptic events arrive one at a time, each carrying an axon number and an input value. The core uses the axon number to fetch one whole row of an on-chip weight memory. It then updates every neuron accumulator in parallel with the weight of that row's column, multiplied by the event's input value. A host loads the weight memory row by row through a write port while the core is idle.

An evaluation step starts with a `stepStart` pulse, which clears all accumulators. The step ends when the input stream delivers an end marker. The core then stops taking events and sends one (neuron index, value) pair per neuron in ascending index order, under a valid/ready handshake. After the last pair is accepted it goes back to idle, and the datapath stays quiet until the next step.

The `MODE` parameter selects the arithmetic variant:
- Mode 0 uses 1-bit inputs, 2-bit weights and 12-bit accumulators, and has no multiplier. Its result is a threshold decision.
- Mode 1 uses 4-bit inputs, 4-bit weights and a 4x4 multiplier feeding 18-bit accumulators. Its result is a 4-bit saturated level.

Top module: `synAccCore`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `evReady` and `outValid` are 0 and the core is idle.
- R2: In idle, `wrEn` writes `wrRow` into memory row `wrAxon`. Bits `[j*WB +: WB]` of that row hold the weight of neuron j as signed two's complement. WB is 2 in mode 0 and 4 in mode 1.
- R3: `wrEn` has no effect while a step is active, that is from the accepted `stepStart` until the last output pair is accepted.
- R4: A `stepStart` pulse in idle zeroes every accumulator and enters the run state, where `evReady` is 1. A `stepStart` outside idle is ignored.
- R5: In the run state, every accepted event with `evEnd` low reads row `evAxon` and updates all neurons. The core accepts one event per cycle with no gaps. Accumulators do not change when no event is being applied.
- R6: In mode 0, the accumulator of neuron j gains the sign-extended 2-bit weight W[axon][j] when the event value is 1, and stays unchanged when it is 0. The accumulator is 12 bits wide.
- R7: In mode 1, the accumulator of neuron j gains the signed weight W[axon][j] times the unsigned 4-bit event value. The accumulator is 18 bits wide.
- R8: An accepted event with `evEnd` high adds nothing and moves the core to output mode. In output mode `evReady` is 0 and `outValid` is 1, and `outNeuron` runs 0,1,...,M-1, advancing only on a cycle with `outReady` high. While `outReady` is low, `outNeuron` and `outValue` hold.
- R9: In mode 0, `outValue` is 1 when the neuron's accumulator, read as signed, is greater than or equal to the signed `threshold` input, and 0 otherwise.
- R10: In mode 1, `outValue` is the accumulator clamped to the range 0..15: negative values give 0 and values above 15 give 15.
- R11: After the pair for neuron M-1 is accepted, the core is idle: `evReady` and `outValid` are 0 until the next `stepStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| stepStart | input | 1 | Begin an evaluation step and clear the accumulators |
| wrEn | input | 1 | Weight row write strobe (idle only) |
| wrAxon | input | log2(NUM_AXONS) | Row to write |
| wrRow | input | NUM_NEURONS*WB | Packed signed weights, neuron j at bits j*WB |
| threshold | input | ACCW | Signed firing threshold (mode 0 only) |
| evValid | input | 1 | Event or end marker present |
| evReady | output | 1 | Core accepts an event this cycle |
| evAxon | input | log2(NUM_AXONS) | Pre-synaptic axon number |
| evValue | input | XB | Input value (1 bit in mode 0, 4 bits unsigned in mode 1) |
| evEnd | input | 1 | Marks the end of the step's events |
| outValid | output | 1 | Output pair present |
| outReady | input | 1 | Consumer takes the pair |
| outNeuron | output | log2(NUM_NEURONS) | Post-synaptic neuron index |
| outValue | output | XB | Neuron result |

## Verification
The bench drives one instance of each mode, with a behavioural model checked every cycle.

- **Saturation.** Weight rows of all-maximum and all-minimum weights push the mode-1 accumulators well past both clamp limits. A clamp that wrapped, or that treated the sum as unsigned, would report wrong levels.
- **Threshold compare.** A step ends with an accumulator exactly equal to the threshold, and a negative threshold is also used. A strict or unsigned compare would flip the firing bit.
- **Ignored writes.** Rows are rewritten while events run and again during output. The affected rows are then used in a later step, so a write gate that leaked would change the results.
- **Handshake corners.** Output backpressure lasts several cycles, events arrive back to back, and one step has no events at all. These expose an index that slips, a dropped event, or stale accumulators.

// File: rtl/synAccPkg.sv
package synAccPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EMIT = 2'd2
  } coreState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAcc;
    logic loadEvent;
    logic loadWeight;
  } ctlStrobe_t;

  function automatic int wBits(input int mode);
    return (mode == 1) ? 4 : 2;
  endfunction

  function automatic int xBits(input int mode);
    return (mode == 1) ? 4 : 1;
  endfunction

  function automatic int accBits(input int mode);
    return (mode == 1) ? 18 : 12;
  endfunction

  function automatic int idxBits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/synAccLane.sv
module synAccLane
  import synAccPkg::*;
#(
  parameter int MODE = 1,
  localparam int WB = wBits(MODE),
  localparam int XB = xBits(MODE),
  localparam int AB = accBits(MODE)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic                 enable,
  input  logic [WB-1:0]        weight,
  input  logic [XB-1:0]        value,
  output logic signed [AB-1:0] acc
);

  logic signed [AB-1:0] addend;

  generate
    if (MODE == 1) begin : g_mul
      localparam int PB = WB + XB + 1;
      logic signed [PB-1:0] prod;
      always_comb begin
        prod   = $signed(weight) * $signed({1'b0, value});
        addend = {{(AB-PB){prod[PB-1]}}, prod};
      end
    end else begin : g_gate
      always_comb begin
        addend = value[0] ? {{(AB-WB){weight[WB-1]}}, weight} : '0;
      end

      AST_ZERO_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (enable && !clear && !value[0]) |=> $stable(acc)); // R6
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (enable) begin
      acc <= acc + addend;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (acc == '0)); // R4

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !clear) |=> $stable(acc)); // R5

endmodule

// File: rtl/synAccCtl.sv
module synAccCtl
  import synAccPkg::*;
#(
  parameter int NUM_NEURONS = 8,
  localparam int IW = idxBits(NUM_NEURONS)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          stepStart,
  input  logic          wrEn,
  input  logic          evValid,
  input  logic          evEnd,
  input  logic          outReady,
  output logic          evReady,
  output logic          outValid,
  output logic [IW-1:0] outIdx,
  output ctlStrobe_t    strobes
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_NEURONS - 1);

  coreState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      outIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (stepStart) state <= ST_RUN;
        end
        ST_RUN: begin
          if (evValid && evEnd) begin
            state  <= ST_EMIT;
            outIdx <= '0;
          end
        end
        ST_EMIT: begin
          if (outReady) begin
            if (outIdx == LAST_IDX) state <= ST_IDLE;
            else outIdx <= outIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    evReady            = (state == ST_RUN);
    outValid           = (state == ST_EMIT);
    strobes.clearAcc   = (state == ST_IDLE) && stepStart;
    strobes.loadEvent  = (state == ST_RUN) && evValid && !evEnd;
    strobes.loadWeight = (state == ST_IDLE) && wrEn;
  end

  AST_NO_INPUT_DURING_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    !(evReady && outValid)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outIdx))); // R8

  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outIdx != LAST_IDX) |=>
      (outValid && outIdx == IW'($past(outIdx) + 1'b1))); // R8

  AST_EMIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outIdx == LAST_IDX) |=> (!outValid && !evReady)); // R11

  AST_MARKER_TO_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    (evReady && evValid && evEnd) |=> (outValid && outIdx == '0)); // R8

endmodule

// File: rtl/synAccDatapath.sv
module synAccDatapath
  import synAccPkg::*;
#(
  parameter int MODE = 1,
  parameter int NUM_AXONS = 32,
  parameter int NUM_NEURONS = 8,
  localparam int WB = wBits(MODE),
  localparam int XB = xBits(MODE),
  localparam int AB = accBits(MODE),
  localparam int AW = idxBits(NUM_AXONS),
  localparam int IW = idxBits(NUM_NEURONS),
  localparam int ROWW = NUM_NEURONS * WB
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobes,
  input  logic [AW-1:0]        wrAxon,
  input  logic [ROWW-1:0]      wrRow,
  input  logic [AW-1:0]        evAxon,
  input  logic [XB-1:0]        evValue,
  input  logic signed [AB-1:0] threshold,
  input  logic [IW-1:0]        outIdx,
  output logic [XB-1:0]        outValue
);

  logic [ROWW-1:0]      weightMem [NUM_AXONS];
  logic [ROWW-1:0]      rowReg;
  logic [XB-1:0]        xReg;
  logic                 pendValid;
  logic signed [AB-1:0] accVec [NUM_NEURONS];
  logic signed [AB-1:0] accSel;

  always_ff @(posedge clk) begin
    if (strobes.loadWeight) weightMem[wrAxon] <= wrRow;
  end

  // Stage 1: fetch the addressed row and hold the input value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      rowReg    <= '0;
      xReg      <= '0;
    end else begin
      pendValid <= strobes.loadEvent;
      if (strobes.loadEvent) begin
        rowReg <= weightMem[evAxon];
        xReg   <= evValue;
      end
    end
  end

  // Stage 2: every neuron column updates in the same cycle
  generate
    for (genvar j = 0; j < NUM_NEURONS; j++) begin : g_lane
      synAccLane #(.MODE(MODE)) u_lane (
        .clk    (clk),
        .rstN   (rstN),
        .clear  (strobes.clearAcc),
        .enable (pendValid),
        .weight (rowReg[j*WB +: WB]),
        .value  (xReg),
        .acc    (accVec[j])
      );
    end
  endgenerate

  assign accSel = accVec[outIdx];

  generate
    if (MODE == 1) begin : g_sat
      logic unusedThr;
      assign unusedThr = ^threshold;
      always_comb begin
        if (accSel[AB-1])          outValue = '0;
        else if (|accSel[AB-2:XB]) outValue = '1;
        else                       outValue = accSel[XB-1:0];
      end
    end else begin : g_fire
      always_comb begin
        outValue = XB'(accSel >= threshold);
      end
    end
  endgenerate

  AST_WRITE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWeight |-> !pendValid); // R3

  AST_CLEAR_NOT_MIXED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAcc |-> !pendValid); // R4

endmodule

// File: rtl/synAccCore.sv
module synAccCore
  import synAccPkg::*;
#(
  parameter int MODE = 1,
  parameter int NUM_AXONS = 32,
  parameter int NUM_NEURONS = 8,
  localparam int WB = wBits(MODE),
  localparam int XB = xBits(MODE),
  localparam int AB = accBits(MODE),
  localparam int AW = idxBits(NUM_AXONS),
  localparam int IW = idxBits(NUM_NEURONS)
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        stepStart,
  input  logic                        wrEn,
  input  logic [AW-1:0]               wrAxon,
  input  logic [NUM_NEURONS*WB-1:0]   wrRow,
  input  logic signed [AB-1:0]        threshold,
  input  logic                        evValid,
  output logic                        evReady,
  input  logic [AW-1:0]               evAxon,
  input  logic [XB-1:0]               evValue,
  input  logic                        evEnd,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [IW-1:0]               outNeuron,
  output logic [XB-1:0]               outValue
);

  ctlStrobe_t strobes;

  synAccCtl #(.NUM_NEURONS(NUM_NEURONS)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .stepStart (stepStart),
    .wrEn      (wrEn),
    .evValid   (evValid),
    .evEnd     (evEnd),
    .outReady  (outReady),
    .evReady   (evReady),
    .outValid  (outValid),
    .outIdx    (outNeuron),
    .strobes   (strobes)
  );

  synAccDatapath #(
    .MODE        (MODE),
    .NUM_AXONS   (NUM_AXONS),
    .NUM_NEURONS (NUM_NEURONS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrAxon    (wrAxon),
    .wrRow     (wrRow),
    .evAxon    (evAxon),
    .evValue   (evValue),
    .threshold (threshold),
    .outIdx    (outNeuron),
    .outValue  (outValue)
  );

endmodule

// File: tb/synAccCore_bench.sv
module synAccCore_bench;

  localparam int N = 32;
  localparam int M = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rstN = 1'b0;
  logic               stepStart = 1'b0;
  logic               wrEn = 1'b0;
  logic [4:0]         wrAxon = '0;
  logic [31:0]        wrRowB = '0;
  logic [15:0]        wrRowA = '0;
  logic signed [11:0] threshA = '0;
  logic signed [17:0] threshB = '0;
  logic               evValid = 1'b0;
  logic [4:0]         evAxon = '0;
  logic [3:0]         evValueB = '0;
  logic               evValueA = 1'b0;
  logic               evEnd = 1'b0;
  logic               outReady = 1'b0;

  logic       evReadyB, outValidB, evReadyA, outValidA;
  logic [2:0] outNeuronB, outNeuronA;
  logic [3:0] outValueB;
  logic       outValueA;

  synAccCore #(.MODE(1), .NUM_AXONS(N), .NUM_NEURONS(M)) u_synAccCore (
    .clk(clk), .rstN(rstN), .stepStart(stepStart), .wrEn(wrEn), .wrAxon(wrAxon),
    .wrRow(wrRowB), .threshold(threshB), .evValid(evValid), .evReady(evReadyB),
    .evAxon(evAxon), .evValue(evValueB), .evEnd(evEnd), .outValid(outValidB),
    .outReady(outReady), .outNeuron(outNeuronB), .outValue(outValueB)
  );

  synAccCore #(.MODE(0), .NUM_AXONS(N), .NUM_NEURONS(M)) u_synAccCoreBin (
    .clk(clk), .rstN(rstN), .stepStart(stepStart), .wrEn(wrEn), .wrAxon(wrAxon),
    .wrRow(wrRowA), .threshold(threshA), .evValid(evValid), .evReady(evReadyA),
    .evAxon(evAxon), .evValue(evValueA), .evEnd(evEnd), .outValid(outValidA),
    .outReady(outReady), .outNeuron(outNeuronA), .outValue(outValueA)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural reference: 0 idle, 1 run, 2 emit
  int mState = 0;
  int mIdx = 0;
  int memA [N][M];
  int memB [N][M];
  int accA [M];
  int accB [M];

  function automatic int clampB(input int v);
    if (v < 0) return 0;
    if (v > 15) return 15;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0;
      mIdx = 0;
    end else begin
      case (mState)
        0: begin
          if (wrEn) begin  // R2
            for (int j = 0; j < M; j++) begin
              memA[wrAxon][j] = $signed(wrRowA[j*2 +: 2]);
              memB[wrAxon][j] = $signed(wrRowB[j*4 +: 4]);
            end
          end
          if (stepStart) begin
            for (int j = 0; j < M; j++) begin
              accA[j] = 0;
              accB[j] = 0;
            end
            mState = 1;
          end
        end
        1: begin
          if (evValid) begin
            if (evEnd) begin
              mState = 2;
              mIdx = 0;
            end else begin
              for (int j = 0; j < M; j++) begin
                if (evValueA) accA[j] += memA[evAxon][j];
                accB[j] += memB[evAxon][j] * int'(evValueB);
              end
            end
          end
        end
        default: begin
          if (outReady) begin
            if (mIdx == M - 1) mState = 0;
            else mIdx++;
          end
        end
      endcase
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(evReadyB == (mState == 1), (mState == 1) ? "R4 evReady mode1" : "R11 evReady mode1",
            int'(evReadyB), int'(mState == 1));
      check(evReadyA == (mState == 1), (mState == 1) ? "R4 evReady mode0" : "R11 evReady mode0",
            int'(evReadyA), int'(mState == 1));
      check(outValidB == (mState == 2), "R8 outValid mode1", int'(outValidB), int'(mState == 2));
      check(outValidA == (mState == 2), "R8 outValid mode0", int'(outValidA), int'(mState == 2));
      if (mState == 2) begin
        check(int'(outNeuronB) == mIdx, "R8 outNeuron mode1", int'(outNeuronB), mIdx);
        check(int'(outNeuronA) == mIdx, "R8 outNeuron mode0", int'(outNeuronA), mIdx);
        check(int'(outValueB) == clampB(accB[mIdx]), "R7,R10 outValue mode1",
              int'(outValueB), clampB(accB[mIdx]));
        check(int'(outValueA) == int'(accA[mIdx] >= int'(threshA)), "R6,R9 outValue mode0",
              int'(outValueA), int'(accA[mIdx] >= int'(threshA)));
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeRow(input int a, input logic [31:0] rb, input logic [15:0] ra);
    wrEn = 1'b1; wrAxon = 5'(a); wrRowB = rb; wrRowA = ra;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic startStep();
    stepStart = 1'b1;
    tick();
    stepStart = 1'b0;
  endtask

  task automatic sendEvent(input int a, input int xb, input bit xa);
    evValid = 1'b1; evEnd = 1'b0; evAxon = 5'(a);
    evValueB = 4'(xb); evValueA = xa;
    tick();
    evValid = 1'b0;
  endtask

  task automatic endStep();
    evValid = 1'b1; evEnd = 1'b1;
    tick();
    evValid = 1'b0; evEnd = 1'b0;
  endtask

  task automatic drain(input int holdCycles, input bit randomReady);
    outReady = 1'b0;
    for (int k = 0; k < holdCycles; k++) tick();  // R8 hold under backpressure
    while (mState != 0) begin
      outReady = randomReady ? (($urandom % 3) != 0) : 1'b1;
      tick();
    end
    outReady = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cycles > 60000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: outputs quiet during reset
    check(evReadyB == 1'b0 && outValidB == 1'b0, "R1 reset mode1", int'(evReadyB), 0);
    check(evReadyA == 1'b0 && outValidA == 1'b0, "R1 reset mode0", int'(evReadyA), 0);
    rstN = 1'b1;
    tick();
    check(evReadyB == 1'b0 && outValidB == 1'b0, "R1 after reset mode1", int'(outValidB), 0);
    check(evReadyA == 1'b0 && outValidA == 1'b0, "R1 after reset mode0", int'(outValidA), 0);

    // R2: load all rows; rows 0 and 1 hold the extreme weights
    writeRow(0, 32'h7777_7777, 16'h5555);
    writeRow(1, 32'h8888_8888, 16'hAAAA);
    for (int a = 2; a < N; a++) writeRow(a, $urandom, 16'($urandom));

    // Step 1: back-to-back events, free-running consumer (R5, R6, R7)
    threshA = 12'sd1;
    startStep();
    for (int e = 0; e < 24; e++) sendEvent(2 + ($urandom % (N - 2)), $urandom % 16, 1'($urandom));
    endStep();
    drain(0, 1'b0);

    // Step 2: writes and a restart while active are ignored (R3, R4), long backpressure (R8)
    threshA = -12'sd1;
    startStep();
    sendEvent(5, 9, 1'b1);
    writeRow(5, 32'h1234_5678, 16'h0F0F);   // R3 write during run
    sendEvent(5, 3, 1'b1);
    stepStart = 1'b1;                       // R4 restart ignored in run
    sendEvent(6, 12, 1'b1);
    stepStart = 1'b0;
    endStep();
    writeRow(6, 32'hFEDC_BA98, 16'hF0F0);   // R3 write during output
    drain(5, 1'b1);

    // Step 3: positive saturation (R10) and firing with negative threshold (R9)
    threshA = -12'sd5;
    startStep();
    for (int e = 0; e < 6; e++) sendEvent(0, 15, 1'b1);
    endStep();
    drain(2, 1'b1);

    // Step 4: negative clamp (R10); below threshold (R9)
    startStep();
    for (int e = 0; e < 3; e++) sendEvent(1, 15, 1'b1);
    endStep();
    drain(0, 1'b0);

    // Step 5: accumulator exactly at threshold (R9); zero input leaves sums (R6)
    threshA = 12'sd2;
    startStep();
    sendEvent(0, 1, 1'b1);
    sendEvent(1, 0, 1'b0);
    sendEvent(0, 1, 1'b1);
    endStep();
    drain(0, 1'b1);

    // Step 6: empty step, accumulators cleared from previous step (R4)
    threshA = 12'sd1;
    startStep();
    endStep();
    drain(1, 1'b0);

    // Step 7: legal idle write (R2) then rows touched while active (R3)
    writeRow(7, 32'h0F1E_2D3C, 16'h9C63);
    threshA = 12'sd0;
    startStep();
    sendEvent(5, 7, 1'b1);
    sendEvent(6, 11, 1'b1);
    sendEvent(7, 13, 1'b1);
    endStep();
    drain(0, 1'b1);

    repeat (3) tick();  // R11 idle after output
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule